// File: doc/BRIEF.md
# Redundant-Weight Decision Encoder

This block turns the raw decisions of a successive-approximation conversion into a plain binary output code. The conversion uses a search with overlapping ranges, so the decision weights are not powers of two. Each raw decision is multiplied by its fixed weight, and the weighted values are summed. Because of this, a wrong early decision that a later redundant decision made up for still gives the correct code.

One 14-bit decision vector arrives with a valid strobe. One clock later the block presents a 12-bit code with its own valid. The weight table is a parameter. The default table has a first-decision weight of 1920 rather than 2048. It has two redundant decisions of 96 and 32, which add 128 of overlap in a 3:1 split. From the eighth decision on, the weights are binary (64, 32, 16, 8, 4, 2, 1). The default weights sum to 4095. A wider table is clamped to the top of the output range.

Top module: `rdw_encoder`

## Requirements
- R1: While reset is high, the next clock edge leaves `code_vld` at 0 and `code` at 0.
- R2: `code_vld` equals the value of `raw_vld` sampled at the previous clock edge.
- R3: When `raw_vld` is 1, the next `code` is the sum of the weights of the decisions that are 1. Decision k (k = 0 first) is bit `raw_bits[13-k]`. The default weights for k = 0..13 are 1920, 1024, 512, 256, 128, 96, 32, 64, 32, 16, 8, 4, 2, 1.
- R4: When only the first decision is set (`raw_bits` = 14'h2000), the result is 1920.
- R5: Two different decision vectors with the same weighted value give the same code. For example, 14'h2000 and 14'h1E00 both give 1920, and 14'h1000 and 14'h0F80 both give 1024.
- R6: All decisions 0 gives 0. All decisions 1 gives 4095.
- R7: A weighted sum above 2**12-1 is clamped to 4095.
- R8: When `raw_vld` is 0, `code` keeps its previous value and `raw_bits` has no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_vld | input | 1 | Decision vector valid |
| raw_bits | input | 14 | Raw decisions, first decision in the MSB |
| code_vld | output | 1 | Output code valid, one clock after raw_vld |
| code | output | 12 | Binary output code |

## Verification
Directed single-decision vectors show that each weight sits at its own bit position. These include the 1920 first decision and the 96 and 32 redundant ones. Pairs of vectors with the same value, one that trusts the first decision and one that rebuilds the same value from later decisions, test the redundancy property that separates this block from plain bit concatenation. Random vectors with random strobes exercise general summation, hold behaviour and valid timing. A second instance with an inflated first weight pushes sums past 4095 so that the clamp is exercised.

// File: rtl/rdw_pkg.sv
package rdw_pkg;

    localparam int unsigned WT_W     = 16;
    localparam int unsigned DEF_NDEC = 14;
    localparam int unsigned DEF_OUTW = 12;

    typedef logic [WT_W-1:0] wt_t;

    // Index k holds the weight of decision k (k = 0 is decided first).
    localparam wt_t [DEF_NDEC-1:0] DEF_WEIGHTS = {
        16'd1,   16'd2,   16'd4,   16'd8,   16'd16,  16'd32,  16'd64,
        16'd32,  16'd96,  16'd128, 16'd256, 16'd512, 16'd1024, 16'd1920
    };

    function automatic logic [31:0] clamp_to(input logic [31:0] v, input int unsigned ow);
        logic [31:0] top;
        top = (32'd1 << ow) - 32'd1;
        return (v > top) ? top : v;
    endfunction

endpackage

// File: rtl/rdw_terms.sv
module rdw_terms
    import rdw_pkg::*;
#(
    parameter int unsigned N_DEC = DEF_NDEC,
    parameter int unsigned ACC_W = 20,
    parameter wt_t [N_DEC-1:0] WEIGHTS = DEF_WEIGHTS
) (
    input  logic [N_DEC-1:0]             raw_bits,
    output logic [N_DEC-1:0][ACC_W-1:0]  terms
);
    // Decision k sits at raw bit N_DEC-1-k.
    for (genvar k = 0; k < N_DEC; k++) begin : g_term
        assign terms[k] = raw_bits[N_DEC-1-k] ? ACC_W'(WEIGHTS[k]) : '0;
    end
endmodule

// File: rtl/rdw_accum.sv
module rdw_accum #(
    parameter int unsigned N_DEC = 14,
    parameter int unsigned ACC_W = 20,
    parameter int unsigned OUT_W = 12
) (
    input  logic [N_DEC-1:0][ACC_W-1:0] terms,
    output logic [OUT_W-1:0]            value
);
    localparam logic [ACC_W-1:0] CEIL = ACC_W'((64'd1 << OUT_W) - 64'd1);

    logic [ACC_W-1:0] total;

    always_comb begin
        total = '0;
        for (int i = 0; i < N_DEC; i++) begin
            total = total + terms[i];
        end
        value = (total > CEIL) ? OUT_W'(CEIL) : OUT_W'(total);
    end
endmodule

// File: rtl/rdw_encoder.sv
module rdw_encoder
    import rdw_pkg::*;
#(
    parameter int unsigned N_DEC = DEF_NDEC,
    parameter int unsigned OUT_W = DEF_OUTW,
    parameter wt_t [N_DEC-1:0] WEIGHTS = DEF_WEIGHTS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              raw_vld,
    input  logic [N_DEC-1:0]  raw_bits,
    output logic              code_vld,
    output logic [OUT_W-1:0]  code
);
    localparam int unsigned ACC_W = WT_W + $clog2(N_DEC) + 1;

    function automatic logic [31:0] table_total();
        logic [31:0] s;
        s = '0;
        for (int i = 0; i < N_DEC; i++) s = s + 32'(WEIGHTS[i]);
        return s;
    endfunction

    localparam logic [OUT_W-1:0] FULL_CODE  = OUT_W'(clamp_to(table_total(), OUT_W));
    localparam logic [OUT_W-1:0] FIRST_CODE = OUT_W'(clamp_to(32'(WEIGHTS[0]), OUT_W));

    logic [N_DEC-1:0][ACC_W-1:0] terms;
    logic [OUT_W-1:0]            sum_code;

    rdw_terms #(.N_DEC(N_DEC), .ACC_W(ACC_W), .WEIGHTS(WEIGHTS)) u_terms (
        .raw_bits (raw_bits),
        .terms    (terms)
    );

    rdw_accum #(.N_DEC(N_DEC), .ACC_W(ACC_W), .OUT_W(OUT_W)) u_accum (
        .terms (terms),
        .value (sum_code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            code_vld <= 1'b0;
            code     <= '0;
        end else begin
            code_vld <= raw_vld;
            if (raw_vld) code <= sum_code;
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!code_vld && code == '0));

    a_r2_vld_follow: assert property (@(posedge clk) disable iff (rst)
        raw_vld |=> code_vld);

    a_r2_vld_idle: assert property (@(posedge clk) disable iff (rst)
        !raw_vld |=> !code_vld);

    a_r8_hold_code: assert property (@(posedge clk) disable iff (rst)
        !raw_vld |=> $stable(code));

    a_r6_all_zero: assert property (@(posedge clk) disable iff (rst)
        (raw_vld && raw_bits == '0) |=> code == '0);

    a_r6_all_one: assert property (@(posedge clk) disable iff (rst)
        (raw_vld && &raw_bits) |=> code == FULL_CODE);

    a_r4_first_only: assert property (@(posedge clk) disable iff (rst)
        (raw_vld && raw_bits == (N_DEC'(1) << (N_DEC-1))) |=> code == FIRST_CODE);
endmodule

// File: tb/sim_rdw_encoder.sv
`timescale 1ns/1ps
module sim_rdw_encoder;
    import rdw_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        raw_vld = 1'b0;
    logic [13:0] raw_bits = '0;
    logic        code_vld, code_vld1;
    logic [11:0] code, code1;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    localparam wt_t [13:0] BIG_W = {
        16'd1, 16'd2, 16'd4, 16'd8, 16'd16, 16'd32, 16'd64,
        16'd32, 16'd96, 16'd128, 16'd256, 16'd512, 16'd1024, 16'd4000
    };

    rdw_encoder u0 (.clk(clk), .rst(rst), .raw_vld(raw_vld), .raw_bits(raw_bits),
                    .code_vld(code_vld), .code(code));
    rdw_encoder #(.WEIGHTS(BIG_W)) u1 (.clk(clk), .rst(rst), .raw_vld(raw_vld),
                    .raw_bits(raw_bits), .code_vld(code_vld1), .code(code1));

    function automatic int expect_code(input logic [13:0] r, input int first_w);
        int w [14] = '{1920, 1024, 512, 256, 128, 96, 32, 64, 32, 16, 8, 4, 2, 1};
        int s = 0;
        w[0] = first_w;
        for (int d = 0; d < 14; d++) if (r[13-d]) s += w[d];
        return (s > 4095) ? 4095 : s;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, sample at next falling edge.
    task automatic apply(input logic [13:0] r, input logic v);
        @(negedge clk);
        raw_bits = r;
        raw_vld  = v;
        @(negedge clk);
    endtask

    int last;

    initial begin
        void'($urandom(32'd24681));
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 vld", int'(code_vld), 0);
        chk("R1 code", int'(code), 0);
        rst = 1'b0;

        apply(14'h2000, 1'b1);
        chk("R2 vld", int'(code_vld), 1);
        chk("R4 first", int'(code), 1920);
        apply(14'h1E00, 1'b1);
        chk("R5 pair1920", int'(code), 1920);
        apply(14'h1000, 1'b1);
        chk("R5 bit1", int'(code), 1024);
        apply(14'h0F80, 1'b1);
        chk("R5 pair1024", int'(code), 1024);
        apply(14'h0000, 1'b1);
        chk("R6 zeros", int'(code), 0);
        apply(14'h3FFF, 1'b1);
        chk("R6 ones", int'(code), 4095);
        chk("R7 clamp ones", int'(code1), 4095);
        apply(14'h3000, 1'b1);
        chk("R7 clamp", int'(code1), 4095);
        chk("R3 two", int'(code), 2944);
        for (int d = 0; d < 14; d++) begin
            apply(14'(1) << (13 - d), 1'b1);
            chk("R3 single", int'(code), expect_code(14'(1) << (13 - d), 1920));
        end
        last = int'(code);
        apply(14'h3FFF, 1'b0);
        chk("R8 hold", int'(code), last);
        chk("R2 idle", int'(code_vld), 0);

        for (int i = 0; i < 300; i++) begin
            logic [13:0] r;
            logic v;
            r = 14'($urandom);
            v = ($urandom % 4) != 0;
            last = int'(code);
            apply(r, v);
            chk("R2 rand", int'(code_vld), int'(v));
            if (v) begin
                chk("R3 rand", int'(code), expect_code(r, 1920));
                chk("R7 rand", int'(code1), expect_code(r, 4000));
            end else begin
                chk("R8 rand", int'(code), last);
            end
        end

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 again", int'(code), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule